// File: doc/BRIEF.md
# Cycle-Counted Coprocessor Interlock Controller

This block sits between a processor's issue stage and a multi-cycle reconfigurable array. It takes one coprocessor command at a time. A command either picks the active configuration, moves a word into or out of the array, starts the array, or saves or restores the array's cycle counter during a context swap. A command is accepted in the cycle where `cmd_valid` and `cmd_ready` are both high. While `cmd_ready` is low, the processor holds the command and is suspended.

Completion is not reported by a done handshake. Starting the array loads a count-down counter, and the array counts as running while that counter is non-zero. Each command carries an interlock flag. With the flag set, the processor waits for the counter to reach zero. With the flag clear, the command goes ahead at once, except for commands that would disturb a running array. A four-entry cache keeps recently used configurations resident. Selecting a resident one costs nothing, and a miss pays a fixed load delay.

Command codes on `cmd_op`: 0 select configuration, 1 put word into array, 2 get word from array, 3 start, 4 save counter, 5 restore counter, 6 and 7 unused.

Top module: `cop_interlock_ctrl`

## Requirements
- R1: Right after reset, `arr_run`, `cfg_loading`, `cfg_cur_vld`, `rsp_valid`, `arr_wr_en` and `arr_start` are all low.
- R2: A select (op 0) of a configuration that is not resident holds `cmd_ready` low for exactly LOAD_CYC (16) cycles. `cfg_loading` is high for LOAD_CYC-1 of those cycles. The command is accepted in the next cycle, and from the following cycle `cfg_cur` equals the selected identifier with `cfg_cur_vld` high.
- R3: A select of a resident configuration is accepted in the cycle it is presented.
- R4: The configuration cache holds WAYS (4) entries. A miss with the cache full evicts the least recently selected entry.
- R5: An accepted start (op 3) with a configuration present pulses `arr_start` in the next cycle and loads the counter with `cmd_arg[15:0]`. `arr_run` then stays high for exactly that many cycles. A count of 0 leaves `arr_run` low.
- R6: A command with `cmd_ilk` high is held (`cmd_ready` low) while `arr_run` is high. It is accepted in the first cycle with `arr_run` low.
- R7: Get, save and start commands with `cmd_ilk` low are accepted at once while the array runs. A start issued while the array runs reloads the counter.
- R8: A put (op 1) is held while `arr_run` is high, whatever the value of `cmd_ilk`. Once accepted, `arr_wr_en` pulses in the next cycle with `arr_wr_data` equal to `cmd_arg`.
- R9: An accepted get (op 2) raises `rsp_valid` for one cycle in the next cycle, with `rsp_data` equal to `arr_rdata` as sampled at acceptance.
- R10: An accepted save (op 4) returns the counter value of the acceptance cycle, zero-extended, on `rsp_data`. An accepted restore (op 5) writes `cmd_arg[15:0]` into the counter, which then keeps counting down.
- R11: A start accepted while no configuration is present does not change the counter and does not pulse `arr_start`.
- R12: A select is held while `arr_run` is high, whatever the value of `cmd_ilk`.
- R13: Ops 6 and 7 are accepted without stall when `cmd_ilk` is low. They cause no response, no array write and no change to the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code |
| cmd_ilk | input | 1 | Interlock flag: wait for counter zero |
| cmd_cfg | input | CFG_W | Configuration identifier for select |
| cmd_arg | input | DATA_W | Put data, start count or restore value |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| arr_rdata | input | DATA_W | Word offered by the array for get |
| arr_wr_en | output | 1 | Put strobe to the array |
| arr_wr_data | output | DATA_W | Put data to the array |
| arr_start | output | 1 | One-cycle array start pulse |
| arr_run | output | 1 | Counter non-zero |
| rsp_valid | output | 1 | Response for get or save |
| rsp_data | output | DATA_W | Response word |
| cfg_loading | output | 1 | Configuration load in progress |
| cfg_load_id | output | CFG_W | Identifier being loaded |
| cfg_cur | output | CFG_W | Active configuration |
| cfg_cur_vld | output | 1 | A configuration is active |

## Verification
The properties assume that a stalled command stays unchanged (valid, code, flag, identifier and argument) until it is accepted. They also assume that `arr_rdata` is stable in the acceptance cycle. The bench drives every command through one task that holds all command fields from presentation until acceptance, and changes inputs only at falling edges. Stall cycles are counted where the bench sees `cmd_ready` low with the command held.

// File: rtl/cop_pkg.sv
package cop_pkg;
  typedef enum logic [2:0] {
    OP_SEL     = 3'd0,
    OP_PUT     = 3'd1,
    OP_GET     = 3'd2,
    OP_START   = 3'd3,
    OP_SAVE    = 3'd4,
    OP_RESTORE = 3'd5
  } cop_op_e;
endpackage

// File: rtl/cop_cycle_counter.sv
module cop_cycle_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load_en)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign cnt  = cnt_q;
  assign busy = (cnt_q != '0);
endmodule

// File: rtl/cop_cfg_cache.sv
module cop_cfg_cache #(
  parameter int WAYS     = 4,
  parameter int CFG_W    = 4,
  parameter int LOAD_CYC = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] lookup_id,
  input  logic             miss_go,
  input  logic             hit_touch,
  output logic             hit,
  output logic             loading,
  output logic [CFG_W-1:0] load_id
);
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int LCNT_W = $clog2(LOAD_CYC);
  localparam logic [WAY_W-1:0]  OLDEST  = WAY_W'(WAYS - 1);
  localparam logic [LCNT_W-1:0] LD_INIT = LCNT_W'(LOAD_CYC - 2);

  logic [CFG_W-1:0]  tag_q [WAYS];
  logic [WAYS-1:0]   vld_q;
  logic [WAY_W-1:0]  age_q [WAYS];
  logic [WAYS-1:0]   match;
  logic [WAY_W-1:0]  hit_way, victim, victim_q, touch_way;
  logic              loading_q, load_done, touch_en;
  logic [LCNT_W-1:0] lcnt_q;
  logic [CFG_W-1:0]  load_id_q;

  for (genvar i = 0; i < WAYS; i++) begin : g_match
    assign match[i] = vld_q[i] && (tag_q[i] == lookup_id);
  end

  always_comb begin
    hit_way = '0;
    victim  = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (match[i])          hit_way = WAY_W'(i);
      if (age_q[i] == OLDEST) victim = WAY_W'(i);
    end
  end

  assign hit       = |match;
  assign load_done = loading_q && (lcnt_q == '0);
  assign touch_en  = load_done || hit_touch;
  assign touch_way = load_done ? victim_q : hit_way;

  always_ff @(posedge clk) begin
    if (rst) begin
      loading_q <= 1'b0;
      lcnt_q    <= '0;
      victim_q  <= '0;
      load_id_q <= '0;
    end else if (miss_go && !loading_q) begin
      loading_q <= 1'b1;
      lcnt_q    <= LD_INIT;
      victim_q  <= victim;
      load_id_q <= lookup_id;
    end else if (load_done) begin
      loading_q <= 1'b0;
    end else if (loading_q) begin
      lcnt_q <= lcnt_q - 1'b1;
    end
  end

  for (genvar i = 0; i < WAYS; i++) begin : g_way
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[i] <= 1'b0;
        tag_q[i] <= '0;
        age_q[i] <= WAY_W'(i);
      end else begin
        if (load_done && (victim_q == WAY_W'(i))) begin
          vld_q[i] <= 1'b1;
          tag_q[i] <= load_id_q;
        end
        if (touch_en) begin
          if (touch_way == WAY_W'(i))
            age_q[i] <= '0;
          else if (age_q[i] < age_q[touch_way])
            age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end

  assign loading = loading_q;
  assign load_id = load_id_q;
endmodule

// File: rtl/cop_issue_ctrl.sv
module cop_issue_ctrl
  import cop_pkg::*;
(
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic       cmd_ilk,
  input  logic       busy,
  input  logic       loading,
  input  logic       hit,
  output logic       ready,
  output logic       accept,
  output logic       miss_go
);
  logic is_sel, is_put;

  assign is_sel = (cmd_op == OP_SEL);
  assign is_put = (cmd_op == OP_PUT);

  always_comb begin
    ready = 1'b1;
    if (loading)
      ready = 1'b0;
    else if ((is_sel || is_put) && busy)
      ready = 1'b0;
    else if (is_sel && !hit)
      ready = 1'b0;
    else if (cmd_ilk && busy)
      ready = 1'b0;
  end

  assign accept  = cmd_valid && ready;
  assign miss_go = cmd_valid && is_sel && !loading && !busy && !hit;
endmodule

// File: rtl/cop_interlock_ctrl.sv
module cop_interlock_ctrl
  import cop_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 16,
  parameter int CFG_W    = 4,
  parameter int WAYS     = 4,
  parameter int LOAD_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic              cmd_ilk,
  input  logic [CFG_W-1:0]  cmd_cfg,
  input  logic [DATA_W-1:0] cmd_arg,
  output logic              cmd_ready,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              arr_wr_en,
  output logic [DATA_W-1:0] arr_wr_data,
  output logic              arr_start,
  output logic              arr_run,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              cfg_loading,
  output logic [CFG_W-1:0]  cfg_load_id,
  output logic [CFG_W-1:0]  cfg_cur,
  output logic              cfg_cur_vld
);
  logic             accept, miss_go, hit, busy;
  logic             acc_sel, acc_start, acc_restore, cnt_load;
  logic [CNT_W-1:0] cnt_q;
  logic             cur_vld_q;
  logic [CFG_W-1:0] cur_q;

  cop_issue_ctrl u_issue (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_ilk   (cmd_ilk),
    .busy      (busy),
    .loading   (cfg_loading),
    .hit       (hit),
    .ready     (cmd_ready),
    .accept    (accept),
    .miss_go   (miss_go)
  );

  assign acc_sel     = accept && (cmd_op == OP_SEL);
  assign acc_start   = accept && (cmd_op == OP_START) && cur_vld_q;
  assign acc_restore = accept && (cmd_op == OP_RESTORE);
  assign cnt_load    = acc_start || acc_restore;

  cop_cfg_cache #(
    .WAYS     (WAYS),
    .CFG_W    (CFG_W),
    .LOAD_CYC (LOAD_CYC)
  ) u_cache (
    .clk       (clk),
    .rst       (rst),
    .lookup_id (cmd_cfg),
    .miss_go   (miss_go),
    .hit_touch (acc_sel),
    .hit       (hit),
    .loading   (cfg_loading),
    .load_id   (cfg_load_id)
  );

  cop_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load_en  (cnt_load),
    .load_val (cmd_arg[CNT_W-1:0]),
    .cnt      (cnt_q),
    .busy     (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q       <= '0;
      cur_vld_q   <= 1'b0;
      arr_wr_en   <= 1'b0;
      arr_wr_data <= '0;
      arr_start   <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
    end else begin
      arr_wr_en <= accept && (cmd_op == OP_PUT);
      arr_start <= acc_start;
      rsp_valid <= accept && ((cmd_op == OP_GET) || (cmd_op == OP_SAVE));
      if (acc_sel) begin
        cur_q     <= cmd_cfg;
        cur_vld_q <= 1'b1;
      end
      if (accept && (cmd_op == OP_PUT))
        arr_wr_data <= cmd_arg;
      if (accept && (cmd_op == OP_GET))
        rsp_data <= arr_rdata;
      else if (accept && (cmd_op == OP_SAVE))
        rsp_data <= DATA_W'(cnt_q);
    end
  end

  assign arr_run     = busy;
  assign cfg_cur     = cur_q;
  assign cfg_cur_vld = cur_vld_q;
endmodule

// File: rtl/cop_interlock_chk.sv
module cop_interlock_chk
  import cop_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic             cmd_ilk,
  input logic             cmd_ready,
  input logic             cfg_loading,
  input logic             cfg_cur_vld,
  input logic             arr_run,
  input logic             arr_start,
  input logic             rsp_valid,
  input logic [CNT_W-1:0] count_q
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  // R2
  load_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_loading |-> !cmd_ready);

  // R2
  load_span_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_loading) |=> cfg_loading);

  // R6
  ilk_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ilk && arr_run) |-> !cmd_ready);

  // R8
  put_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_PUT && arr_run) |-> !cmd_ready);

  // R12
  sel_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == OP_SEL && arr_run) |-> !cmd_ready);

  // R5
  count_down_chk: assert property (@(posedge clk) disable iff (rst)
    (arr_run && !(acc && (cmd_op == OP_START || cmd_op == OP_RESTORE)))
      |=> (count_q == $past(count_q) - 1'b1));

  // R11
  no_cfg_start_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && cmd_op == OP_START && !cfg_cur_vld) |=> !arr_start);

  // R9
  rsp_src_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(acc && (cmd_op == OP_GET || cmd_op == OP_SAVE)));
endmodule

bind cop_interlock_ctrl cop_interlock_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .cmd_ilk     (cmd_ilk),
  .cmd_ready   (cmd_ready),
  .cfg_loading (cfg_loading),
  .cfg_cur_vld (cfg_cur_vld),
  .arr_run     (arr_run),
  .arr_start   (arr_start),
  .rsp_valid   (rsp_valid),
  .count_q     (cnt_q)
);

// File: tb/tb_cop_interlock_ctrl.sv
module tb_cop_interlock_ctrl;
  localparam int DATA_W = 32;
  localparam int CFG_W  = 4;
  localparam int LDC    = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmd_valid = 1'b0;
  logic [2:0]        cmd_op = '0;
  logic              cmd_ilk = 1'b0;
  logic [CFG_W-1:0]  cmd_cfg = '0;
  logic [DATA_W-1:0] cmd_arg = '0;
  logic [DATA_W-1:0] arr_rdata = '0;
  logic              cmd_ready, arr_wr_en, arr_start, arr_run, rsp_valid;
  logic              cfg_loading, cfg_cur_vld;
  logic [DATA_W-1:0] arr_wr_data, rsp_data;
  logic [CFG_W-1:0]  cfg_load_id, cfg_cur;

  int checks = 0;
  int errors = 0;
  int load_seen;

  always #4 clk = ~clk;

  cop_interlock_ctrl dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ilk(cmd_ilk), .cmd_cfg(cmd_cfg), .cmd_arg(cmd_arg),
    .cmd_ready(cmd_ready), .arr_rdata(arr_rdata), .arr_wr_en(arr_wr_en),
    .arr_wr_data(arr_wr_data), .arr_start(arr_start), .arr_run(arr_run),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .cfg_loading(cfg_loading),
    .cfg_load_id(cfg_load_id), .cfg_cur(cfg_cur), .cfg_cur_vld(cfg_cur_vld)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after acceptance.
  task automatic do_cmd(input logic [2:0] op, input logic ilk,
                        input logic [CFG_W-1:0] cfg, input logic [DATA_W-1:0] arg,
                        output int stalls);
    stalls = 0;
    load_seen = 0;
    cmd_valid = 1'b1; cmd_op = op; cmd_ilk = ilk; cmd_cfg = cfg; cmd_arg = arg;
    forever begin
      #1;
      if (cmd_ready) begin
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        break;
      end
      stalls++;
      if (cfg_loading) load_seen++;
      @(negedge clk);
    end
  endtask

  task automatic drain();
    while (arr_run) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 arr_run", arr_run, 0);
    check("R1 cfg_loading", cfg_loading, 0);
    check("R1 cfg_cur_vld", cfg_cur_vld, 0);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 arr_wr_en", arr_wr_en, 0);
    check("R1 arr_start", arr_start, 0);
  endtask

  task automatic t_no_cfg_start();
    int s;
    do_cmd(3'd3, 1'b0, '0, 32'd50, s);
    check("R11 no start pulse", arr_start, 0);
    check("R11 not running", arr_run, 0);
    do_cmd(3'd4, 1'b0, '0, '0, s);
    check("R11 counter unchanged", rsp_data, 0);
  endtask

  task automatic t_sel_miss();
    int s;
    do_cmd(3'd0, 1'b0, 4'd3, '0, s);
    check("R2 miss stall", s, LDC);
    check("R2 loading cycles", load_seen, LDC - 1);
    check("R2 cfg_cur", cfg_cur, 3);
    check("R2 cfg_cur_vld", cfg_cur_vld, 1);
  endtask

  task automatic t_sel_hit();
    int s;
    do_cmd(3'd0, 1'b0, 4'd3, '0, s);
    check("R3 hit stall", s, 0);
  endtask

  task automatic t_lru();
    int s;
    do_cmd(3'd0, 1'b0, 4'd5, '0, s); check("R4 miss 5", s, LDC);
    do_cmd(3'd0, 1'b0, 4'd6, '0, s); check("R4 miss 6", s, LDC);
    do_cmd(3'd0, 1'b0, 4'd7, '0, s); check("R4 miss 7", s, LDC);
    do_cmd(3'd0, 1'b0, 4'd3, '0, s); check("R4 hit 3", s, 0);
    do_cmd(3'd0, 1'b0, 4'd9, '0, s); check("R4 miss 9 evicts 5", s, LDC);
    do_cmd(3'd0, 1'b0, 4'd3, '0, s); check("R4 hit 3 again", s, 0);
    do_cmd(3'd0, 1'b0, 4'd5, '0, s); check("R4 5 was evicted", s, LDC);
    do_cmd(3'd0, 1'b0, 4'd7, '0, s); check("R4 hit 7", s, 0);
    do_cmd(3'd0, 1'b0, 4'd6, '0, s); check("R4 6 was evicted", s, LDC);
    do_cmd(3'd0, 1'b0, 4'd9, '0, s); check("R4 9 was evicted", s, LDC);
  endtask

  task automatic t_start_count();
    int s, n;
    do_cmd(3'd3, 1'b0, '0, 32'h0001_000C, s);
    check("R5 start pulse", arr_start, 1);
    n = 0;
    while (arr_run && n < 1000) begin n++; @(negedge clk); end
    check("R5 run length 12", n, 12);
    check("R5 pulse single", arr_start, 0);
    do_cmd(3'd3, 1'b0, '0, 32'd0, s);
    check("R5 zero start pulse", arr_start, 1);
    check("R5 zero count idle", arr_run, 0);
  endtask

  task automatic t_ilk();
    int s;
    do_cmd(3'd3, 1'b0, '0, 32'd25, s);
    do_cmd(3'd2, 1'b1, '0, '0, s);
    check("R6 interlocked get waits", s, 25);
    check("R6 idle at accept", arr_run, 0);
    do_cmd(3'd3, 1'b0, '0, 32'd8, s);
    do_cmd(3'd3, 1'b1, '0, 32'd3, s);
    check("R6 interlocked start waits", s, 8);
    drain();
  endtask

  task automatic t_nonilk();
    int s;
    do_cmd(3'd3, 1'b0, '0, 32'd40, s);
    do_cmd(3'd2, 1'b0, '0, '0, s);
    check("R7 get no stall", s, 0);
    do_cmd(3'd4, 1'b0, '0, '0, s);
    check("R7 save no stall", s, 0);
    check("R10 save value", rsp_data, 39);
    do_cmd(3'd3, 1'b0, '0, 32'd5, s);
    check("R7 restart no stall", s, 0);
    do_cmd(3'd4, 1'b0, '0, '0, s);
    check("R7 reload value", rsp_data, 5);
    drain();
  endtask

  task automatic t_put();
    int s;
    do_cmd(3'd3, 1'b0, '0, 32'd20, s);
    do_cmd(3'd1, 1'b0, '0, 32'hCAFE_0123, s);
    check("R8 put waits", s, 20);
    check("R8 write strobe", arr_wr_en, 1);
    check("R8 write data", arr_wr_data, 32'hCAFE_0123);
    @(negedge clk);
    check("R8 strobe single", arr_wr_en, 0);
  endtask

  task automatic t_get();
    int s;
    arr_rdata = 32'h1234_5678;
    do_cmd(3'd2, 1'b0, '0, '0, s);
    arr_rdata = 32'hFFFF_0000;
    check("R9 rsp_valid", rsp_valid, 1);
    check("R9 rsp_data", rsp_data, 32'h1234_5678);
    @(negedge clk);
    check("R9 rsp single", rsp_valid, 0);
  endtask

  task automatic t_save_restore();
    int s;
    do_cmd(3'd5, 1'b0, '0, 32'd7, s);
    check("R10 restore runs", arr_run, 1);
    do_cmd(3'd4, 1'b0, '0, '0, s);
    check("R10 restored value", rsp_data, 7);
    do_cmd(3'd2, 1'b1, '0, '0, s);
    check("R10 counts down after restore", s, 6);
  endtask

  task automatic t_sel_busy();
    int s;
    do_cmd(3'd3, 1'b0, '0, 32'd10, s);
    do_cmd(3'd0, 1'b0, 4'd9, '0, s);
    check("R12 select waits", s, 10);
  endtask

  task automatic t_unused_op();
    int s;
    do_cmd(3'd3, 1'b0, '0, 32'd10, s);
    do_cmd(3'd6, 1'b0, '0, 32'd3, s);
    check("R13 op6 no stall", s, 0);
    check("R13 no response", rsp_valid, 0);
    check("R13 no write", arr_wr_en, 0);
    do_cmd(3'd7, 1'b0, '0, 32'd2, s);
    do_cmd(3'd4, 1'b0, '0, '0, s);
    check("R13 counter untouched", rsp_data, 8);
    drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_no_cfg_start();
    t_sel_miss();
    t_sel_hit();
    t_lru();
    t_start_count();
    t_ilk();
    t_nonilk();
    t_put();
    t_get();
    t_save_restore();
    t_sel_busy();
    t_unused_op();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule